// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers interrupt events from eight peripheral sources into one byte-wide flag register on a simple register bus and raises a single interrupt request. Six of the bits are sticky flags. Each one is set by a one-cycle event pulse from its peripheral and stays set until software writes 0 to it. The other two bits are not stored. They reflect, live, a receive-buffer-full level and a transmit-buffer-empty level, and bus writes to them have no effect.

A second byte-wide register holds a per-bit enable. A global-enable input gates the whole request. Flags latch whether or not any enable is set, so software must clear stale flags before enabling a source.

The serial-port flag merges seven completion and bus-condition events. The capture/compare flag ignores its events while that peripheral runs in PWM mode. The top bit can be built as reserved, in which case it never sets.

Top module: `pirq_flag_reg`

## Requirements
- R1: The flag register is read and written at bus address 0x0C and the enable register at 0x8C. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset, the stored flags and all enable bits are 0, and the interrupt request is low.
- R3: An event pulse in a cycle sets its flag at that clock edge, whatever the enable bits and the global enable. Bit positions are: 7 parallel-port, 6 ADC-done, 3 serial-port, 2 capture/compare, 1 timer2-match, 0 timer1-overflow.
- R4: A set flag stays 1 until a write to 0x0C carries 0 in its bit position. A write carrying 1 sets a flag.
- R5: Bit 5 of a flag read equals the receive-full input and bit 4 equals the transmit-empty input in the same cycle. Writes to these two bit positions are ignored.
- R6: The serial-port flag (bit 3) is set by a pulse on any one of its seven event inputs.
- R7: The capture/compare flag (bit 2) is set by a capture pulse or a compare pulse. Both pulses are ignored while PWM mode is high.
- R8: With the reserved option enabled, bit 7 never sets from its event or from a write, and it always reads 0.
- R9: If a write of 0 to a flag and that flag's event fall in the same cycle, the flag ends up 1.
- R10: The interrupt request is high exactly when global enable is high and some bit of the flag read view, ANDed with the enable register, is 1. It follows its inputs in the same cycle.
- R11: The enable register reads back the last byte written to 0x8C and is changed by nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ev_pport | input | 1 | Parallel-port access event pulse |
| ev_adc | input | 1 | Conversion-done event pulse |
| ev_ssp | input | 7 | Serial-port events: transfer done, start done, stop done, restart done, acknowledge done, start seen while idle, stop seen while idle |
| ev_ccp_cap | input | 1 | Capture event pulse |
| ev_ccp_cmp | input | 1 | Compare-match event pulse |
| ccp_pwm_mode | input | 1 | Capture/compare unit in PWM mode |
| ev_tmr2 | input | 1 | Timer2 period-match pulse |
| ev_tmr1 | input | 1 | Timer1 overflow pulse |
| rx_full | input | 1 | Receive buffer full level |
| tx_empty | input | 1 | Transmit buffer empty level |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Event pulses and bus writes take effect at the clock edge that samples them, so a flag read shows them one cycle after they are driven. The live status bits, the read data for a new address and the interrupt request respond in the same cycle as their inputs. The bench drives every input at the falling edge and compares outputs shortly afterwards against a behavioural model. The model's state advances only at the rising edge, so each result is checked in exactly the cycle it is due. A second instance built with the reserved top bit runs in parallel on the same stimulus.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int FLAG_W    = 8;
    localparam int SSP_SRC_W = 7;

    localparam int IDX_PPORT = 7;
    localparam int IDX_ADC   = 6;
    localparam int IDX_RX    = 5;
    localparam int IDX_TX    = 4;
    localparam int IDX_SSP   = 3;
    localparam int IDX_CCP   = 2;
    localparam int IDX_TMR2  = 1;
    localparam int IDX_TMR1  = 0;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] en;
    } pirq_state_t;

endpackage

// File: rtl/pirq_event_merge.sv
module pirq_event_merge
    import pirq_pkg::*;
#(
    parameter int SSP_W          = SSP_SRC_W,
    parameter bit PPORT_RESERVED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_pport_i,
    input  logic             ev_adc_i,
    input  logic [SSP_W-1:0] ev_ssp_i,
    input  logic             ev_ccp_cap_i,
    input  logic             ev_ccp_cmp_i,
    input  logic             ccp_pwm_mode_i,
    input  logic             ev_tmr2_i,
    input  logic             ev_tmr1_i,
    output logic [FLAG_W-1:0] set_o
);

    logic ssp_any;
    logic ccp_any;
    logic pport_ev;

    assign ssp_any = |ev_ssp_i;
    assign ccp_any = (ev_ccp_cap_i | ev_ccp_cmp_i) & ~ccp_pwm_mode_i;

    generate
        if (PPORT_RESERVED) begin : g_pport_rsv
            assign pport_ev = 1'b0;
        end else begin : g_pport_live
            assign pport_ev = ev_pport_i;
        end
    endgenerate

    always_comb begin
        set_o            = '0;
        set_o[IDX_PPORT] = pport_ev;
        set_o[IDX_ADC]   = ev_adc_i;
        set_o[IDX_SSP]   = ssp_any;
        set_o[IDX_CCP]   = ccp_any;
        set_o[IDX_TMR2]  = ev_tmr2_i;
        set_o[IDX_TMR1]  = ev_tmr1_i;
    end

    // Capture/compare events are masked in PWM mode
    assert_pwm_masks_ccp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ccp_pwm_mode_i |-> !set_o[IDX_CCP]);

    // Any serial-port source reaches the merged set line
    assert_ssp_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ssp_i != '0) |-> set_o[IDX_SSP]);

endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank
    import pirq_pkg::*;
#(
    parameter logic [FLAG_W-1:0] STICKY_MASK = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              wr_flag_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] en_o
);

    pirq_state_t st_d;
    pirq_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_flag_i) begin
            st_d.flags = wdata_i;
        end
        // Set events take priority over a clearing write
        st_d.flags = (st_d.flags | set_i) & STICKY_MASK;
        if (wr_en_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;

    generate
        for (genvar k = 0; k < FLAG_W; k++) begin : g_flag_chk
            if (STICKY_MASK[k]) begin : g_sticky
                // An event wins over everything, including a clearing write
                assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    set_i[k] |=> flags_o[k]);
                // Only a write of 0 may drop a set flag
                assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (flags_o[k] && !(wr_flag_i && !wdata_i[k])) |=> flags_o[k]);
            end
        end
    endgenerate

    assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_o));

    assert_en_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (en_o == $past(wdata_i)));

endmodule

// File: rtl/pirq_flag_reg.sv
module pirq_flag_reg
    import pirq_pkg::*;
#(
    parameter int               ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR     = 8'h0C,
    parameter logic [ADDR_W-1:0] EN_ADDR       = 8'h8C,
    parameter bit               PPORT_RESERVED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [FLAG_W-1:0] bus_wdata,
    output logic [FLAG_W-1:0] bus_rdata,
    input  logic              ev_pport,
    input  logic              ev_adc,
    input  logic [SSP_SRC_W-1:0] ev_ssp,
    input  logic              ev_ccp_cap,
    input  logic              ev_ccp_cmp,
    input  logic              ccp_pwm_mode,
    input  logic              ev_tmr2,
    input  logic              ev_tmr1,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              gie,
    output logic              irq
);

    localparam logic [FLAG_W-1:0] LIVE_MASK =
        (FLAG_W'(1) << IDX_RX) | (FLAG_W'(1) << IDX_TX);
    localparam logic [FLAG_W-1:0] RSV_MASK =
        PPORT_RESERVED ? (FLAG_W'(1) << IDX_PPORT) : '0;
    localparam logic [FLAG_W-1:0] STICKY_MASK = ~(LIVE_MASK | RSV_MASK);

    logic              hit_flag;
    logic              hit_en;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] en_q;
    logic [FLAG_W-1:0] view;

    assign hit_flag = (bus_addr == FLAG_ADDR);
    assign hit_en   = (bus_addr == EN_ADDR);

    pirq_event_merge #(
        .SSP_W          (SSP_SRC_W),
        .PPORT_RESERVED (PPORT_RESERVED)
    ) u_merge (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_pport_i     (ev_pport),
        .ev_adc_i       (ev_adc),
        .ev_ssp_i       (ev_ssp),
        .ev_ccp_cap_i   (ev_ccp_cap),
        .ev_ccp_cmp_i   (ev_ccp_cmp),
        .ccp_pwm_mode_i (ccp_pwm_mode),
        .ev_tmr2_i      (ev_tmr2),
        .ev_tmr1_i      (ev_tmr1),
        .set_o          (set_vec)
    );

    pirq_flag_bank #(
        .STICKY_MASK (STICKY_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .wr_flag_i (bus_wr && hit_flag),
        .wr_en_i   (bus_wr && hit_en),
        .wdata_i   (bus_wdata),
        .flags_o   (flags_q),
        .en_o      (en_q)
    );

    always_comb begin
        view          = flags_q & ~LIVE_MASK;
        view[IDX_RX]  = rx_full;
        view[IDX_TX]  = tx_empty;
    end

    always_comb begin
        if (hit_flag) begin
            bus_rdata = view;
        end else if (hit_en) begin
            bus_rdata = en_q;
        end else begin
            bus_rdata = '0;
        end
    end

    assign irq = gie & (|(view & en_q));

    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_flag && !hit_en) |-> (bus_rdata == '0));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    generate
        if (PPORT_RESERVED) begin : g_rsv_chk
            assert_reserved_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
                hit_flag |-> !bus_rdata[IDX_PPORT]);
        end
    endgenerate

endmodule

// File: tb/pirq_flag_reg_tb.sv
module pirq_flag_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h0C;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       ev_pport = 1'b0;
    logic       ev_adc = 1'b0;
    logic [6:0] ev_ssp = 7'h00;
    logic       ev_ccp_cap = 1'b0;
    logic       ev_ccp_cmp = 1'b0;
    logic       ccp_pwm_mode = 1'b0;
    logic       ev_tmr2 = 1'b0;
    logic       ev_tmr1 = 1'b0;
    logic       rx_full = 1'b0;
    logic       tx_empty = 1'b0;
    logic       gie = 1'b0;
    logic [7:0] rdata_a;
    logic [7:0] rdata_b;
    logic       irq_a;
    logic       irq_b;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R2";

    logic [7:0] mf_a = 8'h00;
    logic [7:0] mf_b = 8'h00;
    logic [7:0] men = 8'h00;

    always #10 clk = ~clk;

    pirq_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .ev_pport(ev_pport),
        .ev_adc(ev_adc), .ev_ssp(ev_ssp), .ev_ccp_cap(ev_ccp_cap),
        .ev_ccp_cmp(ev_ccp_cmp), .ccp_pwm_mode(ccp_pwm_mode), .ev_tmr2(ev_tmr2),
        .ev_tmr1(ev_tmr1), .rx_full(rx_full), .tx_empty(tx_empty), .gie(gie),
        .irq(irq_a)
    );

    pirq_flag_reg #(.PPORT_RESERVED(1'b1)) u_dut_rsv (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .ev_pport(ev_pport),
        .ev_adc(ev_adc), .ev_ssp(ev_ssp), .ev_ccp_cap(ev_ccp_cap),
        .ev_ccp_cmp(ev_ccp_cmp), .ccp_pwm_mode(ccp_pwm_mode), .ev_tmr2(ev_tmr2),
        .ev_tmr1(ev_tmr1), .rx_full(rx_full), .tx_empty(tx_empty), .gie(gie),
        .irq(irq_b)
    );

    function automatic logic [7:0] view_of(input logic [7:0] f);
        logic [7:0] v;
        v = f & 8'hCF;
        v[5] = rx_full;
        v[4] = tx_empty;
        return v;
    endfunction

    function automatic logic [7:0] rd_of(input logic [7:0] f);
        if (bus_addr == 8'h0C) return view_of(f);
        if (bus_addr == 8'h8C) return men;
        return 8'h00;
    endfunction

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        logic [7:0] setv;
        logic [7:0] na;
        logic [7:0] nb;
        logic [7:0] ne;
        #2;
        check("rdata", rdata_a, rd_of(mf_a));
        check("rdata_rsv", rdata_b, rd_of(mf_b));
        check("irq", {7'd0, irq_a}, {7'd0, gie && ((view_of(mf_a) & men) != 0)});
        check("irq_rsv", {7'd0, irq_b}, {7'd0, gie && ((view_of(mf_b) & men) != 0)});
        setv = {ev_pport, ev_adc, 2'b00, |ev_ssp,
                (ev_ccp_cap | ev_ccp_cmp) & ~ccp_pwm_mode, ev_tmr2, ev_tmr1};
        na = mf_a;
        nb = mf_b;
        ne = men;
        if (bus_wr && bus_addr == 8'h0C) begin
            na = bus_wdata;
            nb = bus_wdata;
        end
        if (bus_wr && bus_addr == 8'h8C) ne = bus_wdata;
        na = (na | setv) & 8'hCF;
        nb = (nb | setv) & 8'h4F;
        if (!rst_n) begin
            na = 8'h00;
            nb = 8'h00;
            ne = 8'h00;
        end
        @(posedge clk);
        mf_a = na;
        mf_b = nb;
        men = ne;
        @(negedge clk);
    endtask

    task automatic quiet();
        bus_wr = 1'b0;
        ev_pport = 1'b0;
        ev_adc = 1'b0;
        ev_ssp = 7'h00;
        ev_ccp_cap = 1'b0;
        ev_ccp_cmp = 1'b0;
        ev_tmr2 = 1'b0;
        ev_tmr1 = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wr = 1'b1;
        bus_wdata = d;
        cycle();
        bus_wr = 1'b0;
        bus_addr = 8'h0C;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog all requirements: actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R2: reset state
        tag = "R2";
        cycle();
        bus_addr = 8'h8C;
        cycle();
        rst_n = 1'b1;
        bus_addr = 8'h0C;
        cycle();

        // R1: unmapped addresses read 0; a write there changes nothing
        tag = "R1";
        bus_addr = 8'h33;
        cycle();
        wr(8'h0D, 8'hFF);
        bus_addr = 8'h8C;
        cycle();
        bus_addr = 8'h0C;
        cycle();

        // R3: each event alone, no enables, no global enable
        tag = "R3";
        ev_tmr1 = 1'b1; cycle(); quiet(); cycle();
        ev_tmr2 = 1'b1; cycle(); quiet(); cycle();
        ev_adc = 1'b1; cycle(); quiet(); cycle();
        ev_pport = 1'b1; cycle(); quiet(); cycle();

        // R4: hold, clear one, set another by write
        tag = "R4";
        repeat (3) cycle();
        wr(8'h0C, 8'hC2);
        cycle();
        wr(8'h0C, 8'hC3);
        cycle();
        wr(8'h0C, 8'h00);
        cycle();

        // R6: each serial-port source, cleared between
        tag = "R6";
        for (int i = 0; i < 7; i++) begin
            ev_ssp = 7'(1) << i;
            cycle();
            quiet();
            cycle();
            wr(8'h0C, 8'h00);
        end

        // R7: capture, compare, then both masked in PWM mode
        tag = "R7";
        ev_ccp_cap = 1'b1; cycle(); quiet(); cycle();
        wr(8'h0C, 8'h00);
        ev_ccp_cmp = 1'b1; cycle(); quiet(); cycle();
        wr(8'h0C, 8'h00);
        ccp_pwm_mode = 1'b1;
        ev_ccp_cap = 1'b1; cycle(); quiet();
        ev_ccp_cmp = 1'b1; cycle(); quiet(); cycle();
        ccp_pwm_mode = 1'b0;

        // R5: live status bits, writes ignored
        tag = "R5";
        rx_full = 1'b1; cycle();
        tx_empty = 1'b1; cycle();
        rx_full = 1'b0; cycle();
        wr(8'h0C, 8'h30);
        cycle();
        tx_empty = 1'b0;
        wr(8'h0C, 8'h30);
        cycle();

        // R9: event and clearing write in one cycle
        tag = "R9";
        ev_tmr1 = 1'b1; cycle(); quiet();
        bus_addr = 8'h0C; bus_wr = 1'b1; bus_wdata = 8'h00; ev_tmr1 = 1'b1;
        cycle(); quiet(); cycle();
        ev_adc = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
        cycle(); quiet(); cycle();
        wr(8'h0C, 8'h00);

        // R11: enable register write and readback
        tag = "R11";
        wr(8'h8C, 8'hA5);
        bus_addr = 8'h8C; cycle();
        wr(8'h8C, 8'h5A);
        bus_addr = 8'h8C; cycle(); cycle();
        bus_addr = 8'h0C;

        // R10: request gating
        tag = "R10";
        wr(8'h8C, 8'h01);
        ev_tmr1 = 1'b1; cycle(); quiet(); cycle();
        gie = 1'b1; cycle();
        wr(8'h8C, 8'h02); cycle();
        rx_full = 1'b1; wr(8'h8C, 8'h20); cycle();
        rx_full = 1'b0; cycle();
        gie = 1'b0; cycle();
        gie = 1'b1;
        wr(8'h0C, 8'h00);
        wr(8'h8C, 8'h80); cycle();

        // R8: top bit event on both builds (reserved build never sets)
        tag = "R8";
        ev_pport = 1'b1; cycle(); quiet(); cycle();
        wr(8'h0C, 8'h80); cycle();
        wr(8'h0C, 8'h00); cycle();
        gie = 1'b0;
        cycle();

        summary();
        $finish;
    end

endmodule